// File: doc/BRIEF.md
# Dynamic Core Frequency Ratio Controller

This block chooses the core-to-bus clock multiplier that a processor core uses while dynamic frequency scaling is active. At hard reset it captures a 6-bit PLL configuration code. From that code it derives a base multiplier and two flags. One flag says whether halving the base multiplier is allowed, and the other says whether quartering it is allowed.

During operation the block takes two inputs from software control bits (halve and quarter) and two from hardware pins (halve and quarter). It arbitrates between them. A request for a divided mode that the configuration does not allow is turned down, and the block stays in its current mode.

The block has three outputs. The first is the multiplier in use, in half-step units. The second is a mode status field that software reads back. The third is a single-cycle strobe that tells the clock generator the ratio has just changed.

Top module: `dfs_ratio_ctrl`

## Requirements
- R1: While reset is held and in the first cycle after it, the mode status is full speed (code 0), the multiplier equals the base multiplier, and the strobe is low.
- R2: With no pin asserted, the software halve bit on its own selects the halve mode (status code 1, multiplier = base/2) when the configuration allows it.
- R3: With no pin asserted, the software quarter bit selects the quarter mode (status code 2, multiplier = base/4). This also holds when both software bits are set.
- R4: When exactly one hardware pin is asserted, that pin alone selects the mode and the software bits are ignored.
- R5: When both hardware pins are asserted, the block runs at full speed whatever the software bits ask for.
- R6: An accepted request is visible on the outputs after exactly one clock edge. This includes a direct move between the halve and quarter modes, with no intermediate full-speed cycle.
- R7: A request for a divided mode that the configuration does not allow leaves the mode unchanged. From full speed the block stays at full speed; from the halve mode it stays at halve.
- R8: The base multiplier and the support flags are captured only while reset is low. Later changes of the configuration code have no effect.
- R9: The strobe is high for exactly the one cycle after each change of the multiplier in use. It stays low when a request is rejected or the mode is unchanged.
- R10: The status field always reports the mode actually in use (0 full, 1 halve, 2 quarter), not the mode requested.
- R11: The base multiplier in half-steps is the code plus 4. Halving is allowed when the base is even and base/2 is at least 8 half-steps. Quartering is allowed when the base is a multiple of 4 and base/4 is at least 8 half-steps.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low hard reset; the configuration code is captured while it is low |
| pll_cfg_i | input | 6 | PLL configuration code |
| sw_half_i | input | 1 | Software halve request bit |
| sw_quarter_i | input | 1 | Software quarter request bit |
| pin_half_i | input | 1 | Hardware halve request pin |
| pin_quarter_i | input | 1 | Hardware quarter request pin |
| core_mult_o | output | 7 | Multiplier in use, in half-step units |
| mode_status_o | output | 2 | Mode in use: 0 full, 1 halve, 2 quarter |
| switch_strobe_o | output | 1 | One-cycle pulse after each change of the multiplier |

## Verification
Assertions check these properties on every cycle:
- The strobe matches exactly the cycles in which the mode register has changed.
- The mode in use is never one that the captured configuration forbids.
- Both pins together force full speed on the next cycle.
- A single pin, when its mode is allowed, wins on the next cycle.
- The captured base never moves outside reset.

The bench scenarios cover what the assertions cannot. These are the exact multiplier values derived from particular configuration codes, the quarter-over-halve priority between software bits, and the choice between staying at full speed and staying at halve when a request is rejected. They also cover the fact that a change of the configuration code after reset leaves the multiplier untouched.

// File: rtl/dfs_pkg.sv
// Shared types for the dynamic frequency ratio controller.
// Assumes: three modes only; the mode code doubles as the right-shift
// applied to the base multiplier.
package dfs_pkg;
    typedef enum logic [1:0] {
        MODE_FULL    = 2'd0,
        MODE_HALF    = 2'd1,
        MODE_QUARTER = 2'd2
    } dfs_mode_e;
endpackage

// File: rtl/dfs_cfg_latch.sv
// Captures the PLL configuration code while reset is low and derives the
// base multiplier (half-step units) and the support flags for each divide
// step. Assumes: the code is stable during reset; MULT_W holds the code
// plus BASE_OFFSET.
module dfs_cfg_latch #(
    parameter int CFG_W       = 6,
    parameter int MULT_W      = 7,
    parameter int BASE_OFFSET = 4,
    parameter int MIN_DIV_HS  = 8
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic [CFG_W-1:0]  pll_cfg_i,
    output logic [MULT_W-1:0] base_mult_o,
    output logic [1:0]        sup_o
);
    localparam int N_STEPS = 2;

    logic [MULT_W-1:0] base_q;

    // Capture the base multiplier only during hard reset.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            base_q <= MULT_W'(pll_cfg_i) + MULT_W'(BASE_OFFSET);
        end
    end

    // Support flag per divide step: exact division and a minimum result.
    for (genvar d = 0; d < N_STEPS; d++) begin : g_sup
        assign sup_o[d] = (base_q[d:0] == '0) &&
                          ((base_q >> (d + 1)) >= MULT_W'(MIN_DIV_HS));
    end

    assign base_mult_o = base_q;

    // R8: outside reset the captured base never moves.
    assert_base_frozen_R8: assert property (@(posedge clk) disable iff (!rst_n)
        $past(rst_n) |-> $stable(base_q));
endmodule

// File: rtl/dfs_req_arb.sv
// Arbitrates between the software bits and the hardware pins and returns
// the requested mode. Purely combinational. Assumes: the pins are already
// synchronised to clk.
module dfs_req_arb
    import dfs_pkg::*;
(
    input  logic      sw_half_i,
    input  logic      sw_quarter_i,
    input  logic      pin_half_i,
    input  logic      pin_quarter_i,
    output dfs_mode_e req_mode_o
);
    // Pins override software; both pins disable scaling; quarter wins in software.
    always_comb begin
        if (pin_half_i && pin_quarter_i) begin
            req_mode_o = MODE_FULL;
        end else if (pin_quarter_i) begin
            req_mode_o = MODE_QUARTER;
        end else if (pin_half_i) begin
            req_mode_o = MODE_HALF;
        end else if (sw_quarter_i) begin
            req_mode_o = MODE_QUARTER;
        end else if (sw_half_i) begin
            req_mode_o = MODE_HALF;
        end else begin
            req_mode_o = MODE_FULL;
        end
    end
endmodule

// File: rtl/dfs_mode_ctrl.sv
// Holds the mode in use. It accepts a requested mode only if the captured
// configuration allows it, and raises a one-cycle strobe after each change.
// Assumes: full speed is always allowed.
module dfs_mode_ctrl
    import dfs_pkg::*;
#(
    parameter int MULT_W = 7
) (
    input  logic              clk,
    input  logic              rst_n,
    input  dfs_mode_e         req_mode_i,
    input  logic [1:0]        sup_i,
    input  logic [MULT_W-1:0] base_mult_i,
    output dfs_mode_e         mode_o,
    output logic [MULT_W-1:0] mult_o,
    output logic              strobe_o
);
    dfs_mode_e mode_q;
    dfs_mode_e mode_nx;
    logic      accept;

    // Decide whether the requested mode is allowed by the configuration.
    always_comb begin
        unique case (req_mode_i)
            MODE_HALF:    accept = sup_i[0];
            MODE_QUARTER: accept = sup_i[1];
            default:      accept = 1'b1;
        endcase
        mode_nx = accept ? req_mode_i : mode_q;
    end

    // Register the mode in use and the change strobe.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            mode_q   <= MODE_FULL;
            strobe_o <= 1'b0;
        end else begin
            mode_q   <= mode_nx;
            strobe_o <= (mode_nx != mode_q);
        end
    end

    assign mode_o = mode_q;
    assign mult_o = base_mult_i >> mode_q;

    // R9: the strobe marks exactly the cycles in which the mode changed.
    assert_strobe_on_change_R9: assert property (@(posedge clk) disable iff (!rst_n)
        strobe_o == (mode_q != $past(mode_q)));

    // R7: a forbidden divided mode is never in use.
    assert_half_allowed_R7: assert property (@(posedge clk) disable iff (!rst_n)
        (mode_q == MODE_HALF) |-> sup_i[0]);
    assert_quarter_allowed_R7: assert property (@(posedge clk) disable iff (!rst_n)
        (mode_q == MODE_QUARTER) |-> sup_i[1]);
endmodule

// File: rtl/dfs_ratio_ctrl.sv
// Top of the dynamic frequency ratio controller. It chains the
// configuration capture, the request arbitration and the mode register.
// Assumes: the inputs are synchronous to clk.
module dfs_ratio_ctrl
    import dfs_pkg::*;
#(
    parameter int CFG_W       = 6,
    parameter int MULT_W      = 7,
    parameter int BASE_OFFSET = 4,
    parameter int MIN_DIV_HS  = 8
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic [CFG_W-1:0]  pll_cfg_i,
    input  logic              sw_half_i,
    input  logic              sw_quarter_i,
    input  logic              pin_half_i,
    input  logic              pin_quarter_i,
    output logic [MULT_W-1:0] core_mult_o,
    output logic [1:0]        mode_status_o,
    output logic              switch_strobe_o
);
    logic [MULT_W-1:0] base_mult;
    logic [1:0]        sup;
    dfs_mode_e         req_mode;
    dfs_mode_e         cur_mode;

    dfs_cfg_latch #(
        .CFG_W(CFG_W), .MULT_W(MULT_W),
        .BASE_OFFSET(BASE_OFFSET), .MIN_DIV_HS(MIN_DIV_HS)
    ) i_cfg (
        .clk(clk), .rst_n(rst_n), .pll_cfg_i(pll_cfg_i),
        .base_mult_o(base_mult), .sup_o(sup)
    );

    dfs_req_arb i_arb (
        .sw_half_i(sw_half_i), .sw_quarter_i(sw_quarter_i),
        .pin_half_i(pin_half_i), .pin_quarter_i(pin_quarter_i),
        .req_mode_o(req_mode)
    );

    dfs_mode_ctrl #(.MULT_W(MULT_W)) i_ctrl (
        .clk(clk), .rst_n(rst_n), .req_mode_i(req_mode), .sup_i(sup),
        .base_mult_i(base_mult), .mode_o(cur_mode), .mult_o(core_mult_o),
        .strobe_o(switch_strobe_o)
    );

    assign mode_status_o = cur_mode;

    // R5: both pins force full speed on the next cycle.
    assert_both_pins_full_R5: assert property (@(posedge clk) disable iff (!rst_n)
        (pin_half_i && pin_quarter_i) |=> (mode_status_o == MODE_FULL));

    // R4: a lone pin wins over software when its mode is allowed.
    assert_pin_half_wins_R4: assert property (@(posedge clk) disable iff (!rst_n)
        (pin_half_i && !pin_quarter_i && sup[0]) |=> (mode_status_o == MODE_HALF));
    assert_pin_quarter_wins_R4: assert property (@(posedge clk) disable iff (!rst_n)
        (pin_quarter_i && !pin_half_i && sup[1]) |=> (mode_status_o == MODE_QUARTER));
endmodule

// File: tb/test_dfs_ratio_ctrl.sv
// Self-checking bench: a vector table walked by one loop, then directed
// tests for reset, rejected requests and configuration capture.
module test_dfs_ratio_ctrl;
    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic [5:0] pll_cfg = 6'd28;
    logic       sw_h = 1'b0, sw_q = 1'b0, pin_h = 1'b0, pin_q = 1'b0;
    logic [6:0] mult;
    logic [1:0] mode;
    logic       strobe;
    int         n_checks = 0;
    int         n_fail = 0;
    bit         done = 1'b0;

    always #2.5 clk = ~clk;

    dfs_ratio_ctrl i_dfs_ratio_ctrl (
        .clk(clk), .rst_n(rst_n), .pll_cfg_i(pll_cfg),
        .sw_half_i(sw_h), .sw_quarter_i(sw_q),
        .pin_half_i(pin_h), .pin_quarter_i(pin_q),
        .core_mult_o(mult), .mode_status_o(mode), .switch_strobe_o(strobe)
    );

    // Vector: {sw_h, sw_q, pin_h, pin_q, exp_mode[1:0], exp_strobe}, code 28 (base 32)
    localparam logic [6:0] VEC [12] = '{
        7'b1000_01_1,  // R2 halve by software
        7'b1000_01_0,  // R9 no change, no strobe
        7'b1100_10_1,  // R3 both software bits -> quarter
        7'b1000_01_1,  // R6 quarter -> halve directly
        7'b1001_10_1,  // R4 quarter pin beats software halve
        7'b0001_10_0,  // R4 software cleared, pin holds quarter
        7'b0110_01_1,  // R4 halve pin beats software quarter
        7'b0111_00_1,  // R5 both pins -> full
        7'b1011_00_0,  // R5 software ignored
        7'b0000_00_0,  // R10 full held
        7'b0100_10_1,  // R3 quarter by software
        7'b0000_00_1   // R6 back to full
    };

    task automatic check(input string req, input int act, input int exp);
        n_checks++;
        if (act != exp) begin
            n_fail++;
            $display("FAIL %s: actual %0d expected %0d", req, act, exp);
        end
    endtask

    task automatic apply(input logic h, input logic q, input logic ph, input logic pq);
        @(negedge clk);
        sw_h = h; sw_q = q; pin_h = ph; pin_q = pq;
        @(posedge clk);
        @(negedge clk);
    endtask

    task automatic do_reset(input logic [5:0] code);
        @(negedge clk);
        rst_n = 1'b0; pll_cfg = code;
        sw_h = 0; sw_q = 0; pin_h = 0; pin_q = 0;
        repeat (2) @(posedge clk);
        @(negedge clk);
        check("R1 reset mode", mode, 0);
        check("R1 reset strobe", strobe, 0);
        rst_n = 1'b1;
        @(posedge clk);
        @(negedge clk);
        check("R1 mode after reset", mode, 0);
        check("R1 mult after reset", mult, int'(code) + 4);
        check("R1 strobe after reset", strobe, 0);
    endtask

    initial begin
        do_reset(6'd28);
        for (int i = 0; i < 12; i++) begin
            apply(VEC[i][6], VEC[i][5], VEC[i][4], VEC[i][3]);
            check("R10 status vs table", mode, VEC[i][2:1]);
            check("R9 strobe vs table", strobe, VEC[i][0]);
            check("R11 mult vs table", mult, 32 >> VEC[i][2:1]);
        end

        // R8: configuration change after reset has no effect
        @(negedge clk); pll_cfg = 6'd5;
        apply(0, 1, 0, 0);
        check("R8 quarter still allowed", mode, 2);
        check("R8 mult from captured base", mult, 8);
        apply(0, 0, 0, 0);
        check("R8 full mult", mult, 32);

        // Code 12: base 16, halve allowed (8), quarter forbidden (4 < 8)
        do_reset(6'd12);
        apply(0, 1, 0, 0);
        check("R7 full stays full", mode, 0);
        check("R9 no strobe on reject", strobe, 0);
        check("R7 mult unchanged", mult, 16);
        apply(1, 0, 0, 0);
        check("R2 halve allowed", mode, 1);
        check("R11 halve mult", mult, 8);
        apply(1, 1, 0, 0);
        check("R7 halve stays halve", mode, 1);
        check("R9 no strobe on reject", strobe, 0);
        apply(0, 0, 0, 1);
        check("R7 pin quarter rejected", mode, 1);
        apply(0, 0, 1, 1);
        check("R5 both pins full", mode, 0);
        check("R9 strobe on change", strobe, 1);
        check("R5 full mult", mult, 16);

        // Code 5: base 9 odd, nothing allowed
        do_reset(6'd5);
        apply(1, 0, 0, 0);
        check("R7 odd base halve rejected", mode, 0);
        check("R7 mult stays base", mult, 9);
        apply(0, 0, 1, 0);
        check("R7 pin halve rejected", strobe, 0);

        // Code 60: base 64, quarter then halve
        do_reset(6'd60);
        apply(0, 0, 0, 1);
        check("R4 pin quarter", mult, 16);
        apply(0, 0, 1, 0);
        check("R6 direct to halve", mult, 32);
        check("R9 strobe on change", strobe, 1);

        done = 1'b1;
        $display("%0d/%0d checks passed", n_checks - n_fail, n_checks);
        $finish;
    end

    // Watchdog: a hung run counts as a failure and still prints the summary.
    initial begin
        repeat (100000) @(posedge clk);
        if (!done) begin
            n_checks++;
            n_fail++;
            $display("FAIL watchdog: actual timeout expected completion");
            $display("%0d/%0d checks passed", n_checks - n_fail, n_checks);
            $finish;
        end
    end
endmodule